// File: doc/BRIEF.md
# Four-Space Page Map Translator

This block turns a 16-bit virtual word address into an 18-bit physical word address. It keeps four separate page maps, one for each address space: system code, system data, user code and user data. A requester presents the space, the virtual address, a read/write flag and a strobe. One cycle later the block returns the physical address together with exactly one of three outcomes: the translation is usable, the page is absent, or the access is a write to a code space.

A separate load port fills the maps one entry at a time. Each entry holds an 8-bit physical page number and a present bit. The page number is joined to the low ten bits of the virtual address, which are the offset inside a 1K-word page. Physical memory, error correction and the handling of faults by the operating system sit outside this block.

Top module: `page_map_xlate`

## Requirements
- R1: After reset every present bit is clear and the three outcome flags are low, so the first request to any entry reports a page fault.
- R2: The cycle after a request, `pa_o` equals the entry's page number in bits [17:10] and the virtual address bits [9:0] in bits [9:0].
- R3: The entry is chosen by virtual address bits [15:10] within the map chosen by `space_i`. The space codes are 0 for system code, 1 for system data, 2 for user code and 3 for user data.
- R4: A write (`write_i`=1) to a code space (space code 0 or 2) raises `wfault_o` and keeps `valid_o` and `pfault_o` low, whatever the present bit holds.
- R5: A read of any space, and a write to a data space (code 1 or 3), never raises `wfault_o`.
- R6: An access that is not a code-space write, to an entry whose present bit is clear, raises `pfault_o` and keeps `valid_o` low. When the present bit is set, it raises `valid_o` only.
- R7: In the cycle after a cycle with no request, `valid_o`, `pfault_o` and `wfault_o` are all low.
- R8: A map load is seen by requests issued in the following cycle. A request in the same cycle as the load sees the old entry.
- R9: A load changes only the addressed entry of the addressed space. The same index in the other spaces and the other indices in the same space keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request strobe |
| space_i | input | 2 | Address space of the request |
| vaddr_i | input | 16 | Virtual word address |
| write_i | input | 1 | 1 for a write access, 0 for a read |
| ld_en_i | input | 1 | Map entry load strobe |
| ld_space_i | input | 2 | Space whose map is loaded |
| ld_index_i | input | 6 | Virtual page index being loaded |
| ld_ppn_i | input | 8 | Physical page number to store |
| ld_present_i | input | 1 | Present bit to store |
| pa_o | output | 18 | Physical address of the last request |
| valid_o | output | 1 | Translation usable |
| pfault_o | output | 1 | Page absent |
| wfault_o | output | 1 | Write to a code space refused |

## Verification
Translations are tried at the lowest, highest and a middle page index with offsets of all zeros and all ones, so a swapped or shifted field in the address shows up. The same index is loaded with different numbers in different spaces to separate the four maps. Writes are sent to every space, both to present and absent entries, which separates the code-space check from the presence check and shows that protection takes priority. A load and a request to the same entry in one cycle, then again one cycle later, pin down when a load becomes visible.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [1:0] {
        SP_SYS_CODE = 2'd0,
        SP_SYS_DATA = 2'd1,
        SP_USR_CODE = 2'd2,
        SP_USR_DATA = 2'd3
    } space_e;

    // Even space codes are the unmodifiable code spaces.
    function automatic logic space_is_code(input logic lsb);
        return ~lsb;
    endfunction

endpackage

// File: rtl/pmt_map_bank.sv
module pmt_map_bank #(
    parameter int VPN_W = 6,
    parameter int PPN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_present,
    input  logic [VPN_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn,
    output logic             rd_present
);
    localparam int ENTRIES = 1 << VPN_W;

    typedef struct packed {
        logic             present;
        logic [PPN_W-1:0] ppn;
    } entry_t;

    entry_t tbl_d [ENTRIES];
    entry_t tbl_q [ENTRIES];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx].present = wr_present;
            tbl_d[wr_idx].ppn     = wr_ppn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ppn     = tbl_q[rd_idx].ppn;
    assign rd_present = tbl_q[rd_idx].present;

endmodule

// File: rtl/pmt_resolve.sv
module pmt_resolve #(
    parameter int PPN_W = 8,
    parameter int OFF_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic                   code_space,
    input  logic                   write,
    input  logic                   present,
    input  logic [PPN_W-1:0]       ppn,
    input  logic [OFF_W-1:0]       offset,
    output logic [PPN_W+OFF_W-1:0] pa,
    output logic                   valid,
    output logic                   pfault,
    output logic                   wfault
);
    localparam int PA_W = PPN_W + OFF_W;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        logic            valid;
        logic            pfault;
        logic            wfault;
    } res_t;

    res_t res_d;
    res_t res_q;
    logic protect;

    always_comb begin
        protect      = code_space & write;
        res_d        = res_q;
        res_d.valid  = 1'b0;
        res_d.pfault = 1'b0;
        res_d.wfault = 1'b0;
        if (req) begin
            res_d.pa     = {ppn, offset};
            res_d.wfault = protect;
            res_d.pfault = ~protect & ~present;
            res_d.valid  = ~protect & present;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign pa     = res_q.pa;
    assign valid  = res_q.valid;
    assign pfault = res_q.pfault;
    assign wfault = res_q.wfault;

endmodule

// File: rtl/page_map_xlate.sv
module page_map_xlate #(
    parameter int SPACE_W = 2,
    parameter int VA_W    = 16,
    parameter int OFF_W   = 10,
    parameter int PPN_W   = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [SPACE_W-1:0] space_i,
    input  logic [VA_W-1:0]    vaddr_i,
    input  logic               write_i,
    input  logic               ld_en_i,
    input  logic [SPACE_W-1:0] ld_space_i,
    input  logic [VPN_W-1:0]   ld_index_i,
    input  logic [PPN_W-1:0]   ld_ppn_i,
    input  logic               ld_present_i,
    output logic [PA_W-1:0]    pa_o,
    output logic               valid_o,
    output logic               pfault_o,
    output logic               wfault_o
);
    localparam int NUM_SPACES = 1 << SPACE_W;

    logic [PPN_W-1:0] bank_ppn  [NUM_SPACES];
    logic             bank_pres [NUM_SPACES];
    logic [VPN_W-1:0] vpn;

    assign vpn = vaddr_i[VA_W-1:OFF_W];

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
        pmt_map_bank #(
            .VPN_W (VPN_W),
            .PPN_W (PPN_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (ld_en_i && (ld_space_i == SPACE_W'(s))),
            .wr_idx     (ld_index_i),
            .wr_ppn     (ld_ppn_i),
            .wr_present (ld_present_i),
            .rd_idx     (vpn),
            .rd_ppn     (bank_ppn[s]),
            .rd_present (bank_pres[s])
        );
    end

    pmt_resolve #(
        .PPN_W (PPN_W),
        .OFF_W (OFF_W)
    ) u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_i),
        .code_space (pmt_pkg::space_is_code(space_i[0])),
        .write      (write_i),
        .present    (bank_pres[space_i]),
        .ppn        (bank_ppn[space_i]),
        .offset     (vaddr_i[OFF_W-1:0]),
        .pa         (pa_o),
        .valid      (valid_o),
        .pfault     (pfault_o),
        .wfault     (wfault_o)
    );

endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
    parameter int SPACE_W = 2,
    parameter int VA_W    = 16,
    parameter int OFF_W   = 10,
    parameter int PPN_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_i,
    input logic [SPACE_W-1:0]       space_i,
    input logic [VA_W-1:0]          vaddr_i,
    input logic                     write_i,
    input logic [PPN_W+OFF_W-1:0]   pa_o,
    input logic                     valid_o,
    input logic                     pfault_o,
    input logic                     wfault_o
);
    a_r4_code_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !space_i[0] && write_i) |=> (wfault_o && !valid_o && !pfault_o));

    a_r5_no_false_wfault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (space_i[0] || !write_i)) |=> !wfault_o);

    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({valid_o, pfault_o, wfault_o}) <= 1);

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !(valid_o || pfault_o || wfault_o));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (pa_o[OFF_W-1:0] == $past(vaddr_i[OFF_W-1:0])));

    a_r7_request_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> $onehot({valid_o, pfault_o, wfault_o}));
endmodule

bind page_map_xlate pmt_checker #(
    .SPACE_W (SPACE_W),
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .PPN_W   (PPN_W)
) u_chk (.*);

// File: tb/page_map_xlate_bench.sv
module page_map_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  space_i = '0;
    logic [15:0] vaddr_i = '0;
    logic        write_i = 1'b0;
    logic        ld_en_i = 1'b0;
    logic [1:0]  ld_space_i = '0;
    logic [5:0]  ld_index_i = '0;
    logic [7:0]  ld_ppn_i = '0;
    logic        ld_present_i = 1'b0;
    logic [17:0] pa_o;
    logic        valid_o, pfault_o, wfault_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    page_map_xlate u_page_map_xlate (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flags packed as {valid, pfault, wfault}
    task automatic chk_flags(input string tag, input logic [2:0] exp);
        chk(tag, {29'd0, valid_o, pfault_o, wfault_o}, {29'd0, exp});
    endtask

    task automatic load(input logic [1:0] sp, input logic [5:0] idx,
                        input logic [7:0] ppn, input logic pres);
        @(negedge clk);
        ld_en_i = 1'b1; ld_space_i = sp; ld_index_i = idx;
        ld_ppn_i = ppn; ld_present_i = pres;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    // Outputs are sampled on the negedge after the capturing posedge.
    task automatic access(input logic [1:0] sp, input logic [15:0] va, input logic wr);
        @(negedge clk);
        req_i = 1'b1; space_i = sp; vaddr_i = va; write_i = wr;
        @(negedge clk);
        req_i = 1'b0; write_i = 1'b0;
    endtask

    task automatic t_reset;
        chk_flags("R1 flags after reset", 3'b000);
        access(2'd1, 16'h1234, 1'b0);
        chk_flags("R1 first access faults", 3'b010);
        access(2'd3, 16'hFFFF, 1'b1);
        chk_flags("R1 user data absent", 3'b010);
    endtask

    task automatic t_translate;
        load(2'd1, 6'd5, 8'hA3, 1'b1);
        load(2'd1, 6'd63, 8'hFF, 1'b1);
        load(2'd1, 6'd0, 8'h5C, 1'b1);
        access(2'd1, {6'd5, 10'h3FF}, 1'b0);
        chk("R2 pa mid page", {14'd0, pa_o}, {14'd0, 8'hA3, 10'h3FF});
        chk_flags("R6 present gives valid", 3'b100);
        access(2'd1, 16'hFFFF, 1'b0);
        chk("R2 pa top page", {14'd0, pa_o}, 32'h3FFFF);
        access(2'd1, 16'h0000, 1'b0);
        chk("R3 pa page zero", {14'd0, pa_o}, {14'd0, 8'h5C, 10'h000});
    endtask

    task automatic t_independent;
        load(2'd3, 6'd5, 8'h11, 1'b1);
        access(2'd3, {6'd5, 10'h155}, 1'b0);
        chk("R3 user data own map", {14'd0, pa_o}, {14'd0, 8'h11, 10'h155});
        access(2'd1, {6'd5, 10'h2AA}, 1'b0);
        chk("R9 system data untouched", {14'd0, pa_o}, {14'd0, 8'hA3, 10'h2AA});
        chk_flags("R9 system data still present", 3'b100);
        access(2'd0, {6'd5, 10'h000}, 1'b0);
        chk_flags("R3 system code same index absent", 3'b010);
        access(2'd1, {6'd6, 10'h000}, 1'b0);
        chk_flags("R9 neighbour index absent", 3'b010);
    endtask

    task automatic t_protect;
        load(2'd0, 6'd2, 8'h42, 1'b1);
        access(2'd0, {6'd2, 10'h010}, 1'b1);
        chk_flags("R4 write system code present", 3'b001);
        access(2'd2, {6'd9, 10'h010}, 1'b1);
        chk_flags("R4 write user code absent", 3'b001);
        access(2'd0, {6'd2, 10'h010}, 1'b0);
        chk_flags("R5 read system code", 3'b100);
        chk("R2 code read pa", {14'd0, pa_o}, {14'd0, 8'h42, 10'h010});
        access(2'd1, {6'd5, 10'h001}, 1'b1);
        chk_flags("R5 write system data", 3'b100);
        access(2'd3, {6'd7, 10'h001}, 1'b1);
        chk_flags("R5 write user data absent", 3'b010);
    endtask

    task automatic t_absent;
        load(2'd1, 6'd5, 8'hA3, 1'b0);
        access(2'd1, {6'd5, 10'h000}, 1'b0);
        chk_flags("R6 cleared entry faults", 3'b010);
    endtask

    task automatic t_idle;
        access(2'd3, {6'd5, 10'h000}, 1'b0);
        chk_flags("R7 request before idle", 3'b100);
        @(negedge clk);
        chk_flags("R7 idle cycle quiet", 3'b000);
    endtask

    task automatic t_load_timing;
        @(negedge clk);
        ld_en_i = 1'b1; ld_space_i = 2'd2; ld_index_i = 6'd40;
        ld_ppn_i = 8'h77; ld_present_i = 1'b1;
        req_i = 1'b1; space_i = 2'd2; vaddr_i = {6'd40, 10'h123}; write_i = 1'b0;
        @(negedge clk);
        ld_en_i = 1'b0; req_i = 1'b0;
        chk_flags("R8 same-cycle request sees old", 3'b010);
        access(2'd2, {6'd40, 10'h123}, 1'b0);
        chk_flags("R8 next-cycle request sees new", 3'b100);
        chk("R8 new pa", {14'd0, pa_o}, {14'd0, 8'h77, 10'h123});
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_independent();
        t_protect();
        t_absent();
        t_idle();
        t_load_timing();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule